// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Global Mask Save

This block gathers interrupt requests from five sources of a power-management chip: the real-time clock, a push button, the supply monitor, and two switching converters (a step-up and a step-down). A request becomes pending when its source holds its request line high. The push button is an exception: its pending condition depends on which of its two triggers is armed, one for a low input level and one for a high input level. A single active-high interrupt line goes high while at least one pending source is allowed through both its own mask and the global mask. The line stays high until the source's own status is cleared and its request line drops.

Software controls the masks through a small write port with three register codes. One code sets per-source enables, one clears them, and one arms the push-button triggers. Only the bits written as 1 act in the set and clear codes. Bit 7 of the set and clear codes opens or shuts a global gate. Shutting that gate silences every source but leaves the per-source enables in place. Opening it again brings those same enables back into force, including any changes made while the gate was shut.

The global gate is a two-state machine. State GLB_OPEN moves to GLB_SHUT on a clear-code write with bit 7 set. State GLB_SHUT moves to GLB_OPEN on a set-code write with bit 7 set. Every other input leaves the state unchanged. Reset enters GLB_OPEN.

Top module: `irq_aggregator`

## Requirements
- R1: A write with code 0 (set) enables each source whose data bit is 1. Data bits that are 0 leave that source's enable unchanged. The result shows in `mask_o` one cycle later.
- R2: A write with code 1 (clear) disables each source whose data bit is 1. Data bits that are 0 leave that source's enable unchanged. A clear write of 0x01 disables only the clock source (bit 0), and the supply-monitor source (bit 2) stays enabled.
- R3: A clear write with bit 7 set moves the gate to GLB_SHUT. `mask_o[7]` then reads 0, `irq_o` stays low, and the per-source bits `mask_o[4:0]` keep their values.
- R4: A set write with bit 7 set moves the gate to GLB_OPEN. The per-source enables then take effect again as they stand, including any edits made while the gate was shut.
- R5: `mask_o` layout: bit 0 is the clock, bit 1 the push button, bit 2 the supply monitor, bit 3 the step-up converter, bit 4 the step-down converter, bit 7 the global gate (1 = open). Bits 5 and 6 always read 0.
- R6: `pend_o` uses the same bit positions as `mask_o[4:0]`. Each bit equals its source's request level one clock edge earlier.
- R7: A write with code 2 arms the push-button triggers: data bit 0 arms the low-level trigger and data bit 1 arms the high-level trigger. Push-button pending is (low armed and input low) or (high armed and input high). Both triggers are disarmed after reset.
- R8: `irq_o` is 1 one clock edge after a cycle in which some pending bit has its enable set and the gate is GLB_OPEN. Otherwise it is 0.
- R9: `irq_o` stays high for as long as the source request stays high. After the request drops, `pend_o` clears one edge later and `irq_o` clears one edge after that.
- R10: After reset, `pend_o`, `mask_o[4:0]` and `irq_o` are 0, and the gate is GLB_OPEN (`mask_o[7]` = 1). A write with code 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Register code: 0 set, 1 clear, 2 push-button triggers |
| wr_data_i | input | 8 | Write data |
| rtc_req_i | input | 1 | Clock source request level |
| pb_level_i | input | 1 | Push-button input level |
| pwr_req_i | input | 1 | Supply-monitor request level |
| dc1_req_i | input | 1 | Step-up converter request level |
| dc2_req_i | input | 1 | Step-down converter request level |
| pend_o | output | 5 | Pending bits |
| mask_o | output | 8 | Per-source enables and global gate |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The results fall due at fixed delays after each stimulus:
- A write changes `mask_o` at the next edge.
- A source level change shows in `pend_o` at the next edge.
- A change to a pending bit or a mask reaches `irq_o` one edge after that.

The bench model applies these delays when it computes the expected values. It works out the new pending, mask and interrupt values from the inputs held before each edge. It queues them, and the monitor compares them at the falling edge that follows. A scenario that changes a mask therefore sees the effect on the interrupt line in the second check after the write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SRC_RTC = 0;
    localparam int SRC_PB  = 1;
    localparam int SRC_PWR = 2;
    localparam int SRC_DC1 = 3;
    localparam int SRC_DC2 = 4;

    localparam logic [1:0] CODE_SET  = 2'd0;
    localparam logic [1:0] CODE_CLR  = 2'd1;
    localparam logic [1:0] CODE_PBTR = 2'd2;

    typedef enum logic {
        GLB_OPEN = 1'b0,
        GLB_SHUT = 1'b1
    } glb_state_t;
endpackage

// File: rtl/irq_src_enables.sv
module irq_src_enables #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] bits,
    output logic [NUM_SRC-1:0] en_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (set_stb && bits[i]) begin
                en_q[i] <= 1'b1;
            end else if (clr_stb && bits[i]) begin
                en_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_glob_fsm.sv
module irq_glob_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_req,
    input  logic shut_req,
    output logic gate_open
);
    glb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GLB_OPEN: if (shut_req) state_d = GLB_SHUT;
            GLB_SHUT: if (open_req) state_d = GLB_OPEN;
            default:  state_d = GLB_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GLB_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_open = (state_q == GLB_OPEN);
    end
endmodule

// File: rtl/irq_pend_stage.sv
module irq_pend_stage
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_stb,
    input  logic [1:0]         trig_bits,
    input  logic               rtc_req,
    input  logic               pb_level,
    input  logic               pwr_req,
    input  logic               dc1_req,
    input  logic               dc2_req,
    output logic [NUM_SRC-1:0] pend_q
);
    logic pb_lo_arm_q, pb_hi_arm_q;
    logic [NUM_SRC-1:0] live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_lo_arm_q <= 1'b0;
            pb_hi_arm_q <= 1'b0;
        end else if (trig_stb) begin
            pb_lo_arm_q <= trig_bits[0];
            pb_hi_arm_q <= trig_bits[1];
        end
    end

    always_comb begin
        live          = '0;
        live[SRC_RTC] = rtc_req;
        live[SRC_PB]  = (pb_lo_arm_q && !pb_level) || (pb_hi_arm_q && pb_level);
        live[SRC_PWR] = pwr_req;
        live[SRC_DC1] = dc1_req;
        live[SRC_DC2] = dc2_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= live;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_SRC  = 5,
    parameter int GLOB_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rtc_req_i,
    input  logic               pb_level_i,
    input  logic               pwr_req_i,
    input  logic               dc1_req_i,
    input  logic               dc2_req_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic               irq_o
);
    localparam int GAP_W = GLOB_BIT - NUM_SRC;

    logic set_stb, clr_stb, trig_stb;
    logic [NUM_SRC-1:0] en_q, pend_q;
    logic gate_open, irq_q;
    logic [GAP_W-1:0] unused_gap;

    assign set_stb    = wr_en_i && (wr_addr_i == CODE_SET);
    assign clr_stb    = wr_en_i && (wr_addr_i == CODE_CLR);
    assign trig_stb   = wr_en_i && (wr_addr_i == CODE_PBTR);
    assign unused_gap = wr_data_i[GLOB_BIT-1:NUM_SRC];

    irq_src_enables #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
        .bits(wr_data_i[NUM_SRC-1:0]), .en_q(en_q)
    );

    irq_glob_fsm u_glob (
        .clk(clk), .rst_n(rst_n),
        .open_req(set_stb && wr_data_i[GLOB_BIT]),
        .shut_req(clr_stb && wr_data_i[GLOB_BIT]),
        .gate_open(gate_open)
    );

    irq_pend_stage #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .trig_stb(trig_stb),
        .trig_bits(wr_data_i[1:0]),
        .rtc_req(rtc_req_i), .pb_level(pb_level_i), .pwr_req(pwr_req_i),
        .dc1_req(dc1_req_i), .dc2_req(dc2_req_i), .pend_q(pend_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= gate_open && (|(pend_q & en_q));
    end

    always_comb begin
        mask_o                 = '0;
        mask_o[NUM_SRC-1:0]    = en_q;
        mask_o[GLOB_BIT]       = gate_open;
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [1:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic       rtc_req_i,
    input logic [4:0] pend_o,
    input logic [7:0] mask_o,
    input logic       irq_o
);
    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0 && wr_data_i[4]) |=> mask_o[4]);
    // R2
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0]) |=> !mask_o[0]);
    // R3
    glob_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd1 && wr_data_i == 8'h80)
        |=> (!mask_o[7] && $stable(mask_o[4:0])));
    // R4
    glob_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0 && wr_data_i[7]) |=> mask_o[7]);
    // R5
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o[6:5] == 2'b00);
    // R6
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o[0] == $past(rtc_req_i)));
    // R8
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_o[7] |=> !irq_o);
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o[7] && |(pend_o & mask_o[4:0])) |=> irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rtc_req_i(rtc_req_i), .pend_o(pend_o),
    .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic rtc = 1'b0, pb = 1'b0, pwr = 1'b0, dc1 = 1'b0, dc2 = 1'b0;
    logic [4:0] pend;
    logic [7:0] mask;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] pend;
        logic [7:0] mask;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    logic [4:0] e_en = '0, e_pend = '0;
    logic e_glob = 1'b1, e_irq = 1'b0, e_lo = 1'b0, e_hi = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rtc_req_i(rtc), .pb_level_i(pb),
        .pwr_req_i(pwr), .dc1_req_i(dc1), .dc2_req_i(dc2),
        .pend_o(pend), .mask_o(mask), .irq_o(irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks += 3;
            if (pend !== e.pend) begin
                errors++;
                $display("FAIL %s pend actual=%b expected=%b", e.tag, pend, e.pend);
            end
            if (mask !== e.mask) begin
                errors++;
                $display("FAIL %s mask actual=%b expected=%b", e.tag, mask, e.mask);
            end
            if (irq !== e.irq) begin
                errors++;
                $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq);
            end
        end
    end

    // driver: predict the values after the next edge, push them, advance
    task automatic tick(input string tag);
        logic [4:0] n_en = e_en;
        logic n_glob = e_glob, n_lo = e_lo, n_hi = e_hi;
        logic [4:0] n_pend;
        logic n_irq;
        if (wr_en) begin
            case (wr_addr)
                2'd0: begin n_en = e_en | wr_data[4:0]; if (wr_data[7]) n_glob = 1'b1; end
                2'd1: begin n_en = e_en & ~wr_data[4:0]; if (wr_data[7]) n_glob = 1'b0; end
                2'd2: begin n_lo = wr_data[0]; n_hi = wr_data[1]; end
                default: ;
            endcase
        end
        n_pend = {dc2, dc1, pwr, (e_lo && !pb) || (e_hi && pb), rtc};
        n_irq  = e_glob && (|(e_pend & e_en));
        @(posedge clk);
        e_en = n_en; e_glob = n_glob; e_lo = n_lo; e_hi = n_hi;
        e_pend = n_pend; e_irq = n_irq;
        sb_q.push_back('{e_pend, {e_glob, 2'b00, e_en}, e_irq, tag});
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        tick("R10 reset state");
        wr(2'd0, 8'h05, "R1 set 0x05");
        wr(2'd0, 8'h00, "R1 zero bits no effect");
        wr(2'd0, 8'h60, "R5 gap bits read 0");
        rtc = 1'b1;
        tick("R6 clock request pending");
        tick("R8 irq rises");
        pwr = 1'b1;
        tick("R6 supply request pending");
        wr(2'd1, 8'h01, "R2 clear 0x01 only clock");
        tick("R2 supply keeps irq");
        wr(2'd1, 8'h80, "R3 gate shut");
        tick("R3 irq low while shut");
        wr(2'd0, 8'h08, "R4 edit while shut");
        wr(2'd1, 8'h04, "R4 clear supply while shut");
        dc1 = 1'b1;
        tick("R3 pending held but silent");
        wr(2'd0, 8'h80, "R4 gate open");
        tick("R4 restored enables drive irq");
        tick("R9 irq holds");
        dc1 = 1'b0;
        tick("R9 pending drops");
        tick("R9 irq drops");
        wr(2'd3, 8'h9f, "R10 code 3 ignored");
        wr(2'd0, 8'h02, "R7 enable push button");
        tick("R7 no trigger armed");
        wr(2'd2, 8'h01, "R7 arm low");
        tick("R7 low level pending");
        pb = 1'b1;
        tick("R7 high level not pending");
        wr(2'd2, 8'h02, "R7 arm high");
        tick("R7 high level pending");
        rtc = 1'b0; pwr = 1'b0;
        wr(2'd1, 8'h1f, "R2 clear all sources");
        tick("R8 irq off after clear");
        tick("R8 settle");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule